// File: doc/BRIEF.md
# Effective Address Qualifier and Fault Router

This unit sits at the front of a radix translation path. Each request carries a 64-bit effective address, a hypervisor-state flag, a relocation flag and an access type. The unit either forms a real address directly (real mode), or splits the address by its quadrant (the two most significant bits) into a partition identifier and a process identifier taken from two register inputs. A malformed address, or a quadrant a guest may not use, produces a segment fault instead. Results leave through a one-entry registered output stage.

Requests and results use valid/ready. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high when the output slot is empty or is being drained in the same cycle, and `rpt_valid_i` is low. A result stays on its outputs, unchanged, until `res_ready_i` is seen high. The result appears one cycle after it is taken.

The second half of the unit keeps the fault report registers: a data address, a data cause, a hypervisor data address, a hypervisor data cause, an alternate (guest real) address, an exception code and an error code. Faults from the later walk and permission stages come in on a one-cycle report strobe. A segment fault found by the qualifier is reported internally in the cycle its request is taken. The report strobe blocks request acceptance, so the two sources never meet in one cycle.

Top module: `eaq_top`

## Requirements
- R1: In virtual mode, a request whose address has any nonzero bit in bits 61 down to 52 (bit 0 the least significant) gives a result with the segment fault flag set and both identifiers zero.
- R2: With the hypervisor flag set and relocation on, quadrant 0 gives partition 0 and the process register, quadrant 1 gives both registers, quadrant 2 gives the partition register and process 0, and quadrant 3 gives partition 0 and process 0.
- R3: With the hypervisor flag clear, quadrant 0 gives both registers and quadrant 3 gives the partition register with process 0. Quadrants 1 and 2 give a segment fault. This holds whether relocation is on or off.
- R4: With the hypervisor flag set and relocation off (real mode), the result carries the real flag, permission 3'b111 (read, write, execute), no fault and zero identifiers. Its address is the request address with bits 63:60 cleared, ORed with the offset register when request bit 63 is 0. In every other case the result address is the request address with bits 63:62 cleared and the permission is 3'b000.
- R5: A segment fault on a fetch (access code 0) sets the exception code to 1. On a load (code 1, and code 3 is treated as a load) or a store (code 2) it sets the code to 2 and loads the data address register with the request address. The error code becomes 0 in both cases.
- R6: A storage report (hypervisor bit 0) on a fetch sets exception code 3 and error code to the cause. On data it sets code 4, loads the data address register, loads the data cause register with the cause (ORed with bit 25 for a store) and clears the error code.
- R7: A hypervisor storage report always loads the alternate address register with the guest real address. On a fetch it sets code 5 and error code to the cause. On data it sets code 6, loads the hypervisor data address and cause registers (cause ORed with bit 25 for a store) and clears the error code.
- R8: Report registers that the current report does not name, and all report registers in cycles without a report, keep their values.
- R9: `req_ready_o` follows the rule in the description above. A result is held stable while `res_ready_i` is low. The result appears in the cycle after acceptance.
- R10: After reset, no result is valid, the request side is ready, and every report register and both codes read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_ea_i | input | EA_W | Effective address |
| req_hv_i | input | 1 | Hypervisor state |
| req_reloc_i | input | 1 | Relocation enabled |
| req_acc_i | input | 2 | Access: 0 fetch, 1 load, 2 store |
| lpid_reg_i | input | LPID_W | Partition identifier register |
| pid_reg_i | input | PID_W | Process identifier register |
| hrmor_i | input | EA_W | Real-mode offset register |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Result ready |
| res_seg_fault_o | output | 1 | Segment fault |
| res_real_o | output | 1 | Real-mode result |
| res_lpid_o | output | LPID_W | Selected partition identifier |
| res_pid_o | output | PID_W | Selected process identifier |
| res_addr_o | output | EA_W | Real or in-quadrant address |
| res_perm_o | output | 3 | Granted permission {r,w,x} |
| rpt_valid_i | input | 1 | Fault report strobe |
| rpt_hyp_i | input | 1 | 1 hypervisor storage, 0 storage |
| rpt_acc_i | input | 2 | Access type of the faulting access |
| rpt_ea_i | input | EA_W | Faulting effective address |
| rpt_graddr_i | input | EA_W | Guest real address |
| rpt_cause_i | input | CAUSE_W | Fault cause bits |
| dar_o | output | EA_W | Data address register |
| dsisr_o | output | CAUSE_W | Data cause register |
| hdar_o | output | EA_W | Hypervisor data address register |
| hdsisr_o | output | CAUSE_W | Hypervisor data cause register |
| asdr_o | output | EA_W | Alternate (guest real) address register |
| exc_code_o | output | 3 | Exception code |
| err_code_o | output | CAUSE_W | Error code |

## Verification
The qualifier is swept over every combination of hypervisor flag, relocation flag, quadrant and access type. Each combination is tried with a clean address and with each reserved bit set alone. This separates the two mapping tables, the real-mode path and the reserved-bit check, one bit at a time. Real-mode cases cover both values of the top address bit, so the offset OR is seen both applied and skipped. Reports are swept over both report kinds and all access codes. After each report the full register set is compared with a model, so a write to the wrong register or a missing store bit shows up at once. A stalled result with a second request waiting, and a report strobe raised against a pending request, test the back-pressure rules.

// File: rtl/eaq_pkg.sv
package eaq_pkg;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;
  localparam logic [1:0] ACC_STORE = 2'd2;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0,
    EXC_ISEG = 3'd1,
    EXC_DSEG = 3'd2,
    EXC_ISTO = 3'd3,
    EXC_DSTO = 3'd4,
    EXC_HIST = 3'd5,
    EXC_HDST = 3'd6
  } exc_code_e;

  typedef enum logic [1:0] {
    KIND_SEG   = 2'd0,
    KIND_STOR  = 2'd1,
    KIND_HSTOR = 2'd2
  } rep_kind_e;

  localparam logic [2:0] PERM_ALL  = 3'b111;
  localparam logic [2:0] PERM_NONE = 3'b000;

endpackage

// File: rtl/eaq_quadrant_map.sv
module eaq_quadrant_map #(
  parameter int EA_W    = 64,
  parameter int LPID_W  = 12,
  parameter int PID_W   = 20,
  parameter int QUAD_W  = 2,
  parameter int CHECK_W = 10
) (
  input  logic [EA_W-1:0]   ea_i,
  input  logic              hv_i,
  input  logic [LPID_W-1:0] lpid_reg_i,
  input  logic [PID_W-1:0]  pid_reg_i,
  output logic [LPID_W-1:0] lpid_o,
  output logic [PID_W-1:0]  pid_o,
  output logic              fault_o
);

  localparam int QUAD_LO = EA_W - QUAD_W;
  localparam int CHK_HI  = QUAD_LO - 1;
  localparam int CHK_LO  = QUAD_LO - CHECK_W;

  logic [QUAD_W-1:0] quad;
  logic              reserved_set;
  logic              quad_illegal;

  assign quad = ea_i[EA_W-1:QUAD_LO];

  generate
    if (CHECK_W > 0) begin : g_chk
      assign reserved_set = |ea_i[CHK_HI:CHK_LO];
    end else begin : g_nochk
      assign reserved_set = 1'b0;
    end
  endgenerate

  always_comb begin
    lpid_o       = '0;
    pid_o        = '0;
    quad_illegal = 1'b0;
    if (hv_i) begin
      case (quad)
        2'd0: pid_o = pid_reg_i;
        2'd1: begin
          lpid_o = lpid_reg_i;
          pid_o  = pid_reg_i;
        end
        2'd2: lpid_o = lpid_reg_i;
        default: ;
      endcase
    end else begin
      case (quad)
        2'd0: begin
          lpid_o = lpid_reg_i;
          pid_o  = pid_reg_i;
        end
        2'd3: lpid_o = lpid_reg_i;
        default: quad_illegal = 1'b1;
      endcase
    end
  end

  assign fault_o = reserved_set | quad_illegal;

endmodule

// File: rtl/eaq_real_mode.sv
module eaq_real_mode #(
  parameter int EA_W     = 64,
  parameter int RM_CLR_W = 4
) (
  input  logic [EA_W-1:0] ea_i,
  input  logic [EA_W-1:0] hrmor_i,
  output logic [EA_W-1:0] raddr_o
);

  localparam logic [EA_W-1:0] KEEP_MASK = {EA_W{1'b1}} >> RM_CLR_W;

  logic [EA_W-1:0] stripped;

  assign stripped = ea_i & KEEP_MASK;
  assign raddr_o  = ea_i[EA_W-1] ? stripped : (stripped | hrmor_i);

endmodule

// File: rtl/eaq_fault_router.sv
module eaq_fault_router
  import eaq_pkg::*;
#(
  parameter int EA_W      = 64,
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rep_valid_i,
  input  rep_kind_e          rep_kind_i,
  input  logic [1:0]         rep_acc_i,
  input  logic [EA_W-1:0]    rep_ea_i,
  input  logic [EA_W-1:0]    rep_graddr_i,
  input  logic [CAUSE_W-1:0] rep_cause_i,
  output logic [EA_W-1:0]    dar_o,
  output logic [CAUSE_W-1:0] dsisr_o,
  output logic [EA_W-1:0]    hdar_o,
  output logic [CAUSE_W-1:0] hdsisr_o,
  output logic [EA_W-1:0]    asdr_o,
  output exc_code_e          exc_o,
  output logic [CAUSE_W-1:0] err_o
);

  localparam logic [CAUSE_W-1:0] STORE_MASK = CAUSE_W'(1) << STORE_BIT;

  logic               is_data;
  logic [CAUSE_W-1:0] data_cause;

  assign is_data    = (rep_acc_i != ACC_FETCH);
  assign data_cause = rep_cause_i | ((rep_acc_i == ACC_STORE) ? STORE_MASK : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dar_o    <= '0;
      dsisr_o  <= '0;
      hdar_o   <= '0;
      hdsisr_o <= '0;
      asdr_o   <= '0;
      exc_o    <= EXC_NONE;
      err_o    <= '0;
    end else if (rep_valid_i) begin
      case (rep_kind_i)
        KIND_SEG: begin
          err_o <= '0;
          if (is_data) begin
            exc_o <= EXC_DSEG;
            dar_o <= rep_ea_i;
          end else begin
            exc_o <= EXC_ISEG;
          end
        end
        KIND_STOR: begin
          if (is_data) begin
            exc_o   <= EXC_DSTO;
            dsisr_o <= data_cause;
            dar_o   <= rep_ea_i;
            err_o   <= '0;
          end else begin
            exc_o <= EXC_ISTO;
            err_o <= rep_cause_i;
          end
        end
        KIND_HSTOR: begin
          asdr_o <= rep_graddr_i;
          if (is_data) begin
            exc_o    <= EXC_HDST;
            hdsisr_o <= data_cause;
            hdar_o   <= rep_ea_i;
            err_o    <= '0;
          end else begin
            exc_o <= EXC_HIST;
            err_o <= rep_cause_i;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/eaq_top.sv
module eaq_top
  import eaq_pkg::*;
#(
  parameter int EA_W      = 64,
  parameter int LPID_W    = 12,
  parameter int PID_W     = 20,
  parameter int CAUSE_W   = 32,
  parameter int STORE_BIT = 25,
  parameter int QUAD_W    = 2,
  parameter int CHECK_W   = 10,
  parameter int RM_CLR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [EA_W-1:0]    req_ea_i,
  input  logic               req_hv_i,
  input  logic               req_reloc_i,
  input  logic [1:0]         req_acc_i,
  input  logic [LPID_W-1:0]  lpid_reg_i,
  input  logic [PID_W-1:0]   pid_reg_i,
  input  logic [EA_W-1:0]    hrmor_i,
  output logic               res_valid_o,
  input  logic               res_ready_i,
  output logic               res_seg_fault_o,
  output logic               res_real_o,
  output logic [LPID_W-1:0]  res_lpid_o,
  output logic [PID_W-1:0]   res_pid_o,
  output logic [EA_W-1:0]    res_addr_o,
  output logic [2:0]         res_perm_o,
  input  logic               rpt_valid_i,
  input  logic               rpt_hyp_i,
  input  logic [1:0]         rpt_acc_i,
  input  logic [EA_W-1:0]    rpt_ea_i,
  input  logic [EA_W-1:0]    rpt_graddr_i,
  input  logic [CAUSE_W-1:0] rpt_cause_i,
  output logic [EA_W-1:0]    dar_o,
  output logic [CAUSE_W-1:0] dsisr_o,
  output logic [EA_W-1:0]    hdar_o,
  output logic [CAUSE_W-1:0] hdsisr_o,
  output logic [EA_W-1:0]    asdr_o,
  output logic [2:0]         exc_code_o,
  output logic [CAUSE_W-1:0] err_code_o
);

  localparam logic [EA_W-1:0] OFFSET_MASK = {EA_W{1'b1}} >> QUAD_W;

  logic [LPID_W-1:0] map_lpid;
  logic [PID_W-1:0]  map_pid;
  logic              map_fault;
  logic [EA_W-1:0]   rm_addr;

  logic              accept;
  logic              real_mode;
  logic              nxt_fault;
  logic              seg_strobe;

  logic              rep_valid;
  rep_kind_e         rep_kind;
  logic [1:0]        rep_acc;
  logic [EA_W-1:0]   rep_ea;
  logic [EA_W-1:0]   rep_graddr;
  logic [CAUSE_W-1:0] rep_cause;
  exc_code_e         exc_q;

  eaq_quadrant_map #(
    .EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W),
    .QUAD_W(QUAD_W), .CHECK_W(CHECK_W)
  ) u_qmap (
    .ea_i       (req_ea_i),
    .hv_i       (req_hv_i),
    .lpid_reg_i (lpid_reg_i),
    .pid_reg_i  (pid_reg_i),
    .lpid_o     (map_lpid),
    .pid_o      (map_pid),
    .fault_o    (map_fault)
  );

  eaq_real_mode #(
    .EA_W(EA_W), .RM_CLR_W(RM_CLR_W)
  ) u_rmode (
    .ea_i    (req_ea_i),
    .hrmor_i (hrmor_i),
    .raddr_o (rm_addr)
  );

  // request side: blocked while a report strobe is present
  assign req_ready_o = (!res_valid_o || res_ready_i) && !rpt_valid_i;
  assign accept      = req_valid_i && req_ready_o;
  assign real_mode   = req_hv_i && !req_reloc_i;
  assign nxt_fault   = !real_mode && map_fault;
  assign seg_strobe  = accept && nxt_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid_o     <= 1'b0;
      res_seg_fault_o <= 1'b0;
      res_real_o      <= 1'b0;
      res_lpid_o      <= '0;
      res_pid_o       <= '0;
      res_addr_o      <= '0;
      res_perm_o      <= PERM_NONE;
    end else if (accept) begin
      res_valid_o     <= 1'b1;
      res_seg_fault_o <= nxt_fault;
      res_real_o      <= real_mode;
      res_lpid_o      <= (real_mode || nxt_fault) ? '0 : map_lpid;
      res_pid_o       <= (real_mode || nxt_fault) ? '0 : map_pid;
      res_addr_o      <= real_mode ? rm_addr : (req_ea_i & OFFSET_MASK);
      res_perm_o      <= real_mode ? PERM_ALL : PERM_NONE;
    end else if (res_ready_i) begin
      res_valid_o <= 1'b0;
    end
  end

  // report source select; the two never coincide
  always_comb begin
    rep_valid  = rpt_valid_i || seg_strobe;
    if (rpt_valid_i) begin
      rep_kind   = rpt_hyp_i ? KIND_HSTOR : KIND_STOR;
      rep_acc    = rpt_acc_i;
      rep_ea     = rpt_ea_i;
      rep_graddr = rpt_graddr_i;
      rep_cause  = rpt_cause_i;
    end else begin
      rep_kind   = KIND_SEG;
      rep_acc    = req_acc_i;
      rep_ea     = req_ea_i;
      rep_graddr = '0;
      rep_cause  = '0;
    end
  end

  eaq_fault_router #(
    .EA_W(EA_W), .CAUSE_W(CAUSE_W), .STORE_BIT(STORE_BIT)
  ) u_router (
    .clk          (clk),
    .rst_n        (rst_n),
    .rep_valid_i  (rep_valid),
    .rep_kind_i   (rep_kind),
    .rep_acc_i    (rep_acc),
    .rep_ea_i     (rep_ea),
    .rep_graddr_i (rep_graddr),
    .rep_cause_i  (rep_cause),
    .dar_o        (dar_o),
    .dsisr_o      (dsisr_o),
    .hdar_o       (hdar_o),
    .hdsisr_o     (hdsisr_o),
    .asdr_o       (asdr_o),
    .exc_o        (exc_q),
    .err_o        (err_code_o)
  );

  assign exc_code_o = exc_q;

endmodule

// File: rtl/eaq_chk.sv
module eaq_chk #(
  parameter int EA_W    = 64,
  parameter int LPID_W  = 12,
  parameter int PID_W   = 20,
  parameter int CAUSE_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid_i,
  input logic               req_ready_o,
  input logic               res_valid_o,
  input logic               res_ready_i,
  input logic               res_seg_fault_o,
  input logic               res_real_o,
  input logic [LPID_W-1:0]  res_lpid_o,
  input logic [PID_W-1:0]   res_pid_o,
  input logic [EA_W-1:0]    res_addr_o,
  input logic [2:0]         res_perm_o,
  input logic               rpt_valid_i,
  input logic [1:0]         rpt_acc_i,
  input logic [EA_W-1:0]    dar_o,
  input logic [CAUSE_W-1:0] dsisr_o,
  input logic [EA_W-1:0]    hdar_o,
  input logic [CAUSE_W-1:0] hdsisr_o,
  input logic [EA_W-1:0]    asdr_o,
  input logic [2:0]         exc_code_o,
  input logic [CAUSE_W-1:0] err_code_o
);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_addr_o)
      && $stable(res_lpid_o) && $stable(res_pid_o) && $stable(res_seg_fault_o)));

  // R9
  report_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_valid_i |-> !req_ready_o);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rpt_valid_i && !(req_valid_i && req_ready_o)) |=> ($stable(dar_o)
      && $stable(dsisr_o) && $stable(hdar_o) && $stable(hdsisr_o)
      && $stable(asdr_o) && $stable(exc_code_o) && $stable(err_code_o)));

  // R4
  real_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_real_o) |-> (res_perm_o == 3'b111 && !res_seg_fault_o));

  // R1
  fault_ids_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_seg_fault_o) |-> (res_lpid_o == '0 && res_pid_o == '0));

  // R6
  fetch_report_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid_i && rpt_acc_i == 2'd0) |=> ($stable(dar_o) && $stable(dsisr_o)
      && $stable(hdar_o) && $stable(hdsisr_o)));

endmodule

bind eaq_top eaq_chk #(
  .EA_W(EA_W), .LPID_W(LPID_W), .PID_W(PID_W), .CAUSE_W(CAUSE_W)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .res_valid_o     (res_valid_o),
  .res_ready_i     (res_ready_i),
  .res_seg_fault_o (res_seg_fault_o),
  .res_real_o      (res_real_o),
  .res_lpid_o      (res_lpid_o),
  .res_pid_o       (res_pid_o),
  .res_addr_o      (res_addr_o),
  .res_perm_o      (res_perm_o),
  .rpt_valid_i     (rpt_valid_i),
  .rpt_acc_i       (rpt_acc_i),
  .dar_o           (dar_o),
  .dsisr_o         (dsisr_o),
  .hdar_o          (hdar_o),
  .hdsisr_o        (hdsisr_o),
  .asdr_o          (asdr_o),
  .exc_code_o      (exc_code_o),
  .err_code_o      (err_code_o)
);

// File: tb/eaq_top_tb.sv
`timescale 1ns/1ps
module eaq_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [63:0] req_ea_i = '0;
  logic        req_hv_i = 1'b0;
  logic        req_reloc_i = 1'b0;
  logic [1:0]  req_acc_i = '0;
  logic [11:0] lpid_reg_i = 12'hA5C;
  logic [19:0] pid_reg_i = 20'h31F07;
  logic [63:0] hrmor_i = 64'h0000_0012_3450_0000;
  logic        res_valid_o;
  logic        res_ready_i = 1'b1;
  logic        res_seg_fault_o, res_real_o;
  logic [11:0] res_lpid_o;
  logic [19:0] res_pid_o;
  logic [63:0] res_addr_o;
  logic [2:0]  res_perm_o;
  logic        rpt_valid_i = 1'b0;
  logic        rpt_hyp_i = 1'b0;
  logic [1:0]  rpt_acc_i = '0;
  logic [63:0] rpt_ea_i = '0;
  logic [63:0] rpt_graddr_i = '0;
  logic [31:0] rpt_cause_i = '0;
  logic [63:0] dar_o, hdar_o, asdr_o;
  logic [31:0] dsisr_o, hdsisr_o, err_code_o;
  logic [2:0]  exc_code_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [63:0] m_dar = '0, m_hdar = '0, m_asdr = '0;
  logic [31:0] m_dsisr = '0, m_hdsisr = '0, m_err = '0;
  logic [2:0]  m_exc = '0;

  always #2 clk = ~clk;

  eaq_top u_dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    check(dar_o == m_dar,       req, "dar",    dar_o,    m_dar);
    check(dsisr_o == m_dsisr,   req, "dsisr",  {32'd0, dsisr_o},  {32'd0, m_dsisr});
    check(hdar_o == m_hdar,     req, "hdar",   hdar_o,   m_hdar);
    check(hdsisr_o == m_hdsisr, req, "hdsisr", {32'd0, hdsisr_o}, {32'd0, m_hdsisr});
    check(asdr_o == m_asdr,     req, "asdr",   asdr_o,   m_asdr);
    check(exc_code_o == m_exc,  req, "exc",    {61'd0, exc_code_o}, {61'd0, m_exc});
    check(err_code_o == m_err,  req, "err",    {32'd0, err_code_o}, {32'd0, m_err});
  endtask

  // one request, result checked in the cycle after acceptance
  task automatic xact(input logic [63:0] ea, input logic hv, input logic reloc,
                      input logic [1:0] acc);
    logic        e_fault, e_real, bad;
    logic [11:0] e_lpid;
    logic [19:0] e_pid;
    logic [63:0] e_addr;
    logic [2:0]  e_perm;
    string       rq;
    @(negedge clk);
    req_ea_i = ea; req_hv_i = hv; req_reloc_i = reloc; req_acc_i = acc;
    req_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    e_real = hv && !reloc;
    bad = (ea[61:52] != 10'd0);
    e_lpid = '0; e_pid = '0; e_fault = 1'b0;
    if (e_real) begin
      e_addr = {4'h0, ea[59:0]} | (ea[63] ? 64'd0 : hrmor_i);
      e_perm = 3'b111;
      rq = "R4";
    end else begin
      e_addr = {2'b00, ea[61:0]};
      e_perm = 3'b000;
      if (hv) begin
        rq = "R2";
        case (ea[63:62])
          2'd0: e_pid = pid_reg_i;
          2'd1: begin e_lpid = lpid_reg_i; e_pid = pid_reg_i; end
          2'd2: e_lpid = lpid_reg_i;
          default: ;
        endcase
      end else begin
        rq = "R3";
        case (ea[63:62])
          2'd0: begin e_lpid = lpid_reg_i; e_pid = pid_reg_i; end
          2'd3: e_lpid = lpid_reg_i;
          default: e_fault = 1'b1;
        endcase
      end
      if (bad) begin
        e_fault = 1'b1;
        rq = "R1";
      end
      if (e_fault) begin e_lpid = '0; e_pid = '0; end
    end
    check(res_valid_o && res_seg_fault_o == e_fault && res_real_o == e_real
          && res_lpid_o == e_lpid && res_pid_o == e_pid && res_perm_o == e_perm,
          rq, "flags/ids", {res_seg_fault_o, res_real_o, res_perm_o, res_lpid_o, res_pid_o},
          {e_fault, e_real, e_perm, e_lpid, e_pid});
    check(res_addr_o == e_addr, rq, "addr", res_addr_o, e_addr);
    if (e_fault) begin
      m_err = '0;
      if (acc == 2'd0) m_exc = 3'd1;
      else begin m_exc = 3'd2; m_dar = ea; end
      check_regs("R5");
    end else begin
      check_regs("R8");
    end
  endtask

  task automatic report(input logic hyp, input logic [1:0] acc, input logic [63:0] ea,
                        input logic [63:0] gra, input logic [31:0] cause);
    logic [31:0] dc;
    @(negedge clk);
    rpt_valid_i = 1'b1; rpt_hyp_i = hyp; rpt_acc_i = acc;
    rpt_ea_i = ea; rpt_graddr_i = gra; rpt_cause_i = cause;
    #1;
    check(req_ready_o == 1'b0, "R9", "ready during report", {63'd0, req_ready_o}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    rpt_valid_i = 1'b0;
    dc = cause | ((acc == 2'd2) ? 32'h0200_0000 : 32'd0);
    if (hyp) begin
      m_asdr = gra;
      if (acc == 2'd0) begin m_exc = 3'd5; m_err = cause; end
      else begin m_exc = 3'd6; m_hdsisr = dc; m_hdar = ea; m_err = '0; end
      check_regs("R7");
    end else begin
      if (acc == 2'd0) begin m_exc = 3'd3; m_err = cause; end
      else begin m_exc = 3'd4; m_dsisr = dc; m_dar = ea; m_err = '0; end
      check_regs("R6");
    end
  endtask

  initial begin
    logic [63:0] ea_a, ea_b;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    check(!res_valid_o && req_ready_o, "R10", "handshake after reset",
          {62'd0, res_valid_o, req_ready_o}, 64'd1);
    check_regs("R10");

    // qualifier sweep
    for (int hv = 0; hv < 2; hv++)
      for (int rl = 0; rl < 2; rl++)
        for (int q = 0; q < 4; q++)
          for (int a = 0; a < 3; a++)
            for (int b = -1; b < 10; b++) begin
              logic [63:0] ea;
              ea = {q[1:0], 10'd0, 52'h0_ABCD_1234_5678} ^ {60'd0, hv[0], rl[0], a[1:0]};
              if (b >= 0) ea[52 + b] = 1'b1;
              xact(ea, hv[0], rl[0], a[1:0]);
            end

    // access code 3 behaves as a load for segment faults
    xact(64'h4000_0000_0000_1230, 1'b0, 1'b1, 2'd3);

    // report sweep
    for (int h = 0; h < 2; h++)
      for (int a = 0; a < 4; a++)
        for (int c = 0; c < 3; c++)
          report(h[0], a[1:0], 64'h1111_0000_0000_0000 + 64'(h * 64 + a * 8 + c),
                 64'h0000_2222_0000_0000 + 64'(a * 16 + c),
                 (32'h4000_0000 >> c) | 32'(a));

    // idle hold
    repeat (5) @(negedge clk);
    check_regs("R8");

    // back-pressure: result held while stalled, second request waits
    ea_a = 64'h0000_0000_0000_0A10;
    ea_b = 64'hC000_0000_0000_0B20;
    @(negedge clk);
    res_ready_i = 1'b0;
    req_ea_i = ea_a; req_hv_i = 1'b1; req_reloc_i = 1'b1; req_acc_i = 2'd1;
    req_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_ea_i = ea_b;
    #1;
    check(req_ready_o == 1'b0, "R9", "ready while stalled", {63'd0, req_ready_o}, 64'd0);
    repeat (3) begin
      @(negedge clk);
      check(res_valid_o && res_addr_o == ea_a && res_pid_o == pid_reg_i, "R9",
            "held result", res_addr_o, ea_a);
    end
    res_ready_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    check(res_valid_o && res_addr_o == {2'b00, ea_b[61:0]} && res_lpid_o == 12'd0,
          "R9", "second result", res_addr_o, {2'b00, ea_b[61:0]});
    @(negedge clk);
    check(!res_valid_o, "R9", "drained", {63'd0, res_valid_o}, 64'd0);
    check_regs("R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule